// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into CAN bit timing. A prescaler divides the clock into time quanta. A segment counter then walks each bit through three phases: a one-quantum sync segment, a phase that ends at the sample point, and a phase that ends the bit. Falling (recessive-to-dominant) edges on the receive line keep the bit clock aligned with the bus. When the bus is idle, such an edge causes a hard sync. Inside a frame it causes a resync, and the size of that adjustment is limited by a programmable jump width. The receive line is sampled either once or three times with a majority vote.

Two 8-bit configuration registers hold all timing settings. Software can change them only while the init-mode input is high. Outside init mode they read back their contents when the full-view input is high, and all ones otherwise. The outputs are the sampled bit with a one-cycle sample strobe, and a one-cycle transmit strobe at the start of every bit. Frame decoding is left to the logic around the block.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2 × (P + 1) clock cycles. P is the 6-bit prescale field in bits 5:0 of configuration word 0 (wr_sel/rd_sel = 0).
- R2: With no edges on rx, a bit lasts 1 + (A + 1) + (B + 1) quanta. A is the 4-bit field in bits 3:0 of configuration word 1 (select = 1). B is the 3-bit field in bits 6:4 of the same word.
- R3: sample_strobe pulses for exactly one cycle when the phase before the sample point ends. The first sync quantum of a bit plus (A + 1) quanta separate the tick behind tx_strobe from the tick behind sample_strobe.
- R4: tx_strobe pulses for exactly one cycle each time a bit ends and the next sync segment begins. A hard sync does not raise it.
- R5: When bit 7 of word 1 is 1, sample_bit is the majority of the rx levels seen on the last three quantum ticks, the sample-point tick included. When that bit is 0, sample_bit is the level seen on the sample-point tick alone.
- R6: A falling rx edge while bus_idle is 1 causes a hard sync. The quantum counter and the bit both restart at the sync segment. The sample strobe follows 2 + (A + 2) × quantum cycles after the rx change is driven.
- R7: A falling edge in the phase before the sample point, detected at quantum index q of that phase, lengthens that phase by min(q + 1, J + 1) quanta. J is the 2-bit jump field in bits 7:6 of word 0.
- R8: A falling edge in the phase after the sample point, detected at quantum index q, shortens that phase by min(B + 1 − q, J + 1) quanta.
- R9: At most one resync is applied per bit. Edges detected during the sync segment are ignored.
- R10: A write changes a configuration word only while init_mode is 1. Writes at other times leave the stored word unchanged.
- R11: rd_data shows the selected word one cycle after the read select when init_mode or full_view is 1, and 0xFF otherwise.
- R12: After reset, both words are 0x00 and rd_data, sample_strobe, sample_bit and tx_strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Opens the configuration words for writing |
| full_view | input | 1 | Selects true readback outside init mode |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Word written (0 or 1) |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Word read (0 or 1) |
| rd_data | output | 8 | Registered read value |
| bus_idle | input | 1 | High between frames; turns a falling edge into a hard sync |
| rx | input | 1 | Receive line, 1 = recessive |
| sample_strobe | output | 1 | One-cycle pulse at each sample point |
| sample_bit | output | 1 | Bit value taken at the last sample point |
| tx_strobe | output | 1 | One-cycle pulse at the start of each bit |

## Verification
Several properties are checked on every cycle. Writes are blocked outside init mode and readback is forced to all ones when full_view is low. Quantum ticks never come back to back. The strobes line up with the segment state. A phase grows or shrinks by no more than the jump width, and the phase lengths stay frozen once a bit has used its resync. Other behaviour shows up only in the bench scenarios, where a cycle-level model tracks the timing of each strobe: the absolute bit and sample timing for a given configuration, the hard-sync restart delay, the choice between a one-sample and a three-sample vote when the line glitches, and the fact that an edge in the sync segment leaves the sample point where it was.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int REG_W = 8;
  localparam int BRP_W = 6;
  localparam int SJW_W = 2;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cbt_regs.sv
module cbt_regs #(
  parameter int W = cbt_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_mode,
  input  logic         full_view,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] cfg0,
  output logic [W-1:0] cfg1,
  output logic [W-1:0] rd_data
);
  localparam int NWORDS = 2;
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] bank [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= '0;
      else if (wr_en && init_mode && (wr_sel == 1'(g)))
        bank[g] <= wr_data;
    end
  end

  assign cfg0 = bank[0];
  assign cfg1 = bank[1];

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (init_mode || full_view)
      rd_data <= rd_sel ? bank[1] : bank[0];
    else
      rd_data <= ALL_ONES;
  end

  // R10: a write outside init mode leaves both words untouched
  assert_locked_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !init_mode) |=> ($stable(cfg0) && $stable(cfg1)));

  // R11: masked readback outside init mode without full view
  assert_masked_read_R11: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && !full_view) |=> (rd_data == ALL_ONES));
endmodule

// File: rtl/cbt_tq_gen.sv
module cbt_tq_gen #(
  parameter int PW = cbt_pkg::BRP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [PW-1:0] brp,
  output logic          tick
);
  localparam int CW = PW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = {brp, 1'b1};
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart || tick)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end

  // R1: a quantum is at least two clocks long, so ticks never touch
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> !tick);
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int T1W = cbt_pkg::TS1_W,
  parameter int T2W = cbt_pkg::TS2_W,
  parameter int JW  = cbt_pkg::SJW_W,
  parameter int LW  = cbt_pkg::LEN_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           rx_lvl,
  input  logic           fall_edge,
  input  logic           bus_idle,
  input  logic [T1W-1:0] tseg1,
  input  logic [T2W-1:0] tseg2,
  input  logic [JW-1:0]  sjw,
  input  logic           triple,
  output logic           hard_sync,
  output logic           sample_strobe,
  output logic           sample_bit,
  output logic           tx_strobe
);
  seg_e          seg;
  logic [LW-1:0] qcnt, ph1_len, ph2_len;
  logic          resynced;
  logic [1:0]    hist;

  logic [LW-1:0] jump, lag, rem, step1, step2, ph1_adj, ph2_adj, qcnt_inc;
  logic          rs_ok, at_sp, end_bit, picked;

  assign hard_sync = fall_edge && bus_idle;
  assign rs_ok     = fall_edge && !bus_idle && !resynced && (seg != SEG_SYNC);

  always_comb begin
    qcnt_inc = qcnt + LW'(1);
    jump     = LW'(sjw) + LW'(1);
    lag      = qcnt_inc;
    rem      = ph2_len - qcnt;
    step1    = (lag < jump) ? lag : jump;
    step2    = (rem < jump) ? rem : jump;
    ph1_adj  = ph1_len + ((rs_ok && seg == SEG_PH1) ? step1 : '0);
    ph2_adj  = ph2_len - ((rs_ok && seg == SEG_PH2) ? step2 : '0);
    at_sp    = (seg == SEG_PH1) && (qcnt == ph1_adj - LW'(1));
    end_bit  = (seg == SEG_PH2) && (qcnt_inc >= ph2_adj);
    picked   = triple ? vote3(hist[1], hist[0], rx_lvl) : rx_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg           <= SEG_SYNC;
      qcnt          <= '0;
      ph1_len       <= LW'(1);
      ph2_len       <= LW'(1);
      resynced      <= 1'b0;
      hist          <= '0;
      sample_strobe <= 1'b0;
      sample_bit    <= 1'b0;
      tx_strobe     <= 1'b0;
    end else begin
      sample_strobe <= !hard_sync && tick && at_sp;
      tx_strobe     <= !hard_sync && tick && end_bit;
      if (hard_sync) begin
        seg      <= SEG_SYNC;
        qcnt     <= '0;
        resynced <= 1'b0;
      end else begin
        ph1_len <= ph1_adj;
        ph2_len <= ph2_adj;
        if (rs_ok) resynced <= 1'b1;
        if (tick) begin
          hist <= {hist[0], rx_lvl};
          if (at_sp) sample_bit <= picked;
          case (seg)
            SEG_SYNC: begin
              seg      <= SEG_PH1;
              qcnt     <= '0;
              ph1_len  <= LW'(tseg1) + LW'(1);
              ph2_len  <= LW'(tseg2) + LW'(1);
              resynced <= 1'b0;
            end
            SEG_PH1: begin
              if (at_sp) begin
                seg  <= SEG_PH2;
                qcnt <= '0;
              end else begin
                qcnt <= qcnt_inc;
              end
            end
            SEG_PH2: begin
              if (end_bit) begin
                seg  <= SEG_SYNC;
                qcnt <= '0;
              end else begin
                qcnt <= qcnt_inc;
              end
            end
            default: begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end
          endcase
        end
      end
    end
  end

  // R3: a sample strobe always coincides with entry into the post-sample phase
  assert_sample_enters_ph2_R3: assert property (@(posedge clk) disable iff (rst)
    sample_strobe |-> (seg == SEG_PH2 && qcnt == '0));

  // R4: a transmit strobe marks the very start of a sync segment
  assert_tx_at_sync_R4: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> (seg == SEG_SYNC && qcnt == '0));

  // R7: the pre-sample phase grows by at most the jump width
  assert_lengthen_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_PH1 && $past(seg) == SEG_PH1) |->
      (int'(ph1_len) <= int'($past(ph1_len)) + int'($past(sjw)) + 1));

  // R8: the post-sample phase shrinks by at most the jump width
  assert_shorten_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_PH2 && $past(seg) == SEG_PH2) |->
      (int'(ph2_len) + int'($past(sjw)) + 1 >= int'($past(ph2_len))));

  // R9: once a bit has used its resync, its phase lengths stay frozen
  assert_single_resync_R9: assert property (@(posedge clk) disable iff (rst)
    (resynced && $past(resynced) && seg == $past(seg)) |->
      (ph1_len == $past(ph1_len) && ph2_len == $past(ph2_len)));
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int REG_W = cbt_pkg::REG_W,
  parameter int BRP_W = cbt_pkg::BRP_W,
  parameter int SJW_W = cbt_pkg::SJW_W,
  parameter int TS1_W = cbt_pkg::TS1_W,
  parameter int TS2_W = cbt_pkg::TS2_W,
  parameter int LEN_W = cbt_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic             full_view,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             sample_strobe,
  output logic             sample_bit,
  output logic             tx_strobe
);
  localparam int TRIPLE_BIT = REG_W - 1;

  logic [REG_W-1:0] cfg0, cfg1;
  logic             rx_s1, rx_s2, fall_edge, tick, hard_sync;

  cbt_regs #(.W(REG_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .init_mode(init_mode),
    .full_view(full_view),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .cfg0     (cfg0),
    .cfg1     (cfg1),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx;
      rx_s2 <= rx_s1;
    end
  end

  assign fall_edge = rx_s2 && !rx_s1;

  cbt_tq_gen #(.PW(BRP_W)) u_tq (
    .clk    (clk),
    .rst    (rst),
    .restart(hard_sync),
    .brp    (cfg0[BRP_W-1:0]),
    .tick   (tick)
  );

  cbt_bit_fsm #(
    .T1W(TS1_W),
    .T2W(TS2_W),
    .JW (SJW_W),
    .LW (LEN_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .rx_lvl       (rx_s1),
    .fall_edge    (fall_edge),
    .bus_idle     (bus_idle),
    .tseg1        (cfg1[TS1_W-1:0]),
    .tseg2        (cfg1[TS1_W +: TS2_W]),
    .sjw          (cfg0[REG_W-1 -: SJW_W]),
    .triple       (cfg1[TRIPLE_BIT]),
    .hard_sync    (hard_sync),
    .sample_strobe(sample_strobe),
    .sample_bit   (sample_bit),
    .tx_strobe    (tx_strobe)
  );

  // R4: the two strobes never fire together
  assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (rst)
    !(sample_strobe && tx_strobe));
endmodule

// File: tb/sim_can_bit_timing.sv
module sim_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_mode = 1'b1, full_view = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       bus_idle = 1'b0, rx = 1'b1;
  logic       sample_strobe, sample_bit, tx_strobe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_bit_timing u0 (
    .clk(clk), .rst(rst), .init_mode(init_mode), .full_view(full_view),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .bus_idle(bus_idle), .rx(rx),
    .sample_strobe(sample_strobe), .sample_bit(sample_bit), .tx_strobe(tx_strobe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_r0, m_r1, m_cnt, m_ph, m_q, m_len1, m_len2, e_rd;
  bit m_rx1, m_rx2, m_done, e_ss, e_sb, e_tx;
  bit m_hist[$];
  int t_lim, t_jmp, t_l1, t_l2, t_step, votes;
  bit t_edge, t_hard, t_tick, t_rs, t_sp, t_eb;

  always @(posedge clk) begin
    if (rst) begin
      m_r0 = 0; m_r1 = 0; m_cnt = 0; m_ph = 0; m_q = 0; m_len1 = 1; m_len2 = 1;
      m_rx1 = 1; m_rx2 = 1; m_done = 0; e_ss = 0; e_sb = 0; e_tx = 0; e_rd = 0;
      m_hist = {1'b0, 1'b0};
    end else begin
      t_edge = m_rx2 && !m_rx1;
      t_hard = t_edge && bus_idle;
      t_lim  = 2 * ((m_r0 % 64) + 1) - 1;
      t_tick = (m_cnt >= t_lim);
      t_jmp  = (m_r0 / 64) + 1;
      t_l1 = m_len1; t_l2 = m_len2;
      t_rs = t_edge && !bus_idle && !m_done && (m_ph != 0);
      if (t_rs && m_ph == 1) begin
        t_step = (m_q + 1 < t_jmp) ? m_q + 1 : t_jmp;
        t_l1 = t_l1 + t_step;
      end
      if (t_rs && m_ph == 2) begin
        t_step = (t_l2 - m_q < t_jmp) ? t_l2 - m_q : t_jmp;
        t_l2 = t_l2 - t_step;
      end
      t_sp = (m_ph == 1) && (m_q == t_l1 - 1);
      t_eb = (m_ph == 2) && (m_q + 1 >= t_l2);
      e_ss = !t_hard && t_tick && t_sp;
      e_tx = !t_hard && t_tick && t_eb;
      if (e_ss) begin
        if (m_r1 >= 128) begin
          votes = int'(m_hist[0]) + int'(m_hist[1]) + int'(m_rx1);
          e_sb = (votes >= 2);
        end else e_sb = m_rx1;
      end
      e_rd = (init_mode || full_view) ? (rd_sel ? m_r1 : m_r0) : 255;
      if (wr_en && init_mode) begin
        if (wr_sel) m_r1 = int'(wr_data); else m_r0 = int'(wr_data);
      end
      m_cnt = (t_hard || t_tick) ? 0 : m_cnt + 1;
      if (t_hard) begin
        m_ph = 0; m_q = 0; m_done = 0;
      end else begin
        m_len1 = t_l1; m_len2 = t_l2;
        if (t_rs) m_done = 1;
        if (t_tick) begin
          m_hist.push_back(m_rx1);
          void'(m_hist.pop_front());
          if (m_ph == 0) begin
            m_ph = 1; m_q = 0; m_done = 0;
            m_len1 = (m_r1 % 16) + 1; m_len2 = ((m_r1 / 16) % 8) + 1;
          end else if (m_ph == 1) begin
            if (t_sp) begin m_ph = 2; m_q = 0; end else m_q++;
          end else begin
            if (t_eb) begin m_ph = 0; m_q = 0; end else m_q++;
          end
        end
      end
      m_rx2 = m_rx1; m_rx1 = rx;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(sample_strobe == e_ss, "R3 sample_strobe vs model", int'(sample_strobe), int'(e_ss));
      chk(sample_bit == e_sb, "R5 sample_bit vs model", int'(sample_bit), int'(e_sb));
      chk(tx_strobe == e_tx, "R4 tx_strobe vs model", int'(tx_strobe), int'(e_tx));
      chk(int'(rd_data) == e_rd, "R11 rd_data vs model", int'(rd_data), e_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit sel, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_tx(output int at);
    at = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (tx_strobe) begin at = cyc; break; end
    end
    if (at < 0) chk(1'b0, "R4 tx_strobe timeout", 0, 1);
  endtask

  task automatic wait_ss(output int at);
    at = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (sample_strobe) begin at = cyc; break; end
    end
    if (at < 0) chk(1'b0, "R3 sample_strobe timeout", 0, 1);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic vote_trial(input bit exp_bit, input string tag);
    int c, s;
    wait_tx(c);
    rx = 1'b0;                 // falls inside the sync segment: ignored
    wait_until(c + 7*6 - 2); rx = 1'b1;
    @(negedge clk); rx = 1'b0; // high only on the sample-point tick
    wait_ss(s);
    chk(s == c + 42, tag, s - c, 42);
    chk(sample_bit == exp_bit, tag, int'(sample_bit), int'(exp_bit));
    rx = 1'b1;
    wait_tx(c); wait_tx(c);
  endtask

  initial begin
    int a, b, c, s, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(rd_data == 8'h00, "R12 rd_data after reset", int'(rd_data), 0);
    chk(!sample_strobe && !tx_strobe && !sample_bit, "R12 outputs after reset",
        int'({sample_strobe, tx_strobe, sample_bit}), 0);

    // R10 locked write
    init_mode = 1'b0;
    wr(1'b0, 8'hAA);
    rd_sel = 1'b0; @(negedge clk);
    chk(rd_data == 8'h00, "R10 write outside init mode ignored", int'(rd_data), 0);

    // configure: J=1, P=1 (quantum 4 clocks); A=3, B=2, single sample
    init_mode = 1'b1;
    wr(1'b0, 8'h41);
    wr(1'b1, 8'h23);
    rd_sel = 1'b1; @(negedge clk);
    chk(rd_data == 8'h23, "R11 readback in init mode", int'(rd_data), 'h23);
    init_mode = 1'b0; full_view = 1'b0; @(negedge clk);
    chk(rd_data == 8'hFF, "R11 masked readback", int'(rd_data), 'hFF);
    full_view = 1'b1; rd_sel = 1'b0; @(negedge clk);
    chk(rd_data == 8'h41, "R11 full-view readback", int'(rd_data), 'h41);

    // R1 / R2 bit period: 8 quanta x 4 clocks
    wait_tx(a); wait_tx(a);
    @(negedge clk);
    chk(!tx_strobe, "R4 tx_strobe lasts one cycle", int'(tx_strobe), 0);
    wait_tx(b);
    chk(b - a == 32, "R1 R2 bit period", b - a, 32);

    // R3 sample point 5 quanta after the bit start
    wait_tx(c); wait_ss(s);
    chk(s - c == 20, "R3 sample point position", s - c, 20);
    @(negedge clk);
    chk(!sample_strobe, "R3 sample_strobe lasts one cycle", int'(sample_strobe), 0);

    // R9 sync-segment edge ignored, R7 lengthen, R9 second edge ignored
    wait_tx(c);
    rx = 1'b0; @(negedge clk); rx = 1'b1;
    wait_until(c + 11); rx = 1'b0;      // detected at quantum index 2 of phase 1
    wait_until(c + 14); rx = 1'b1;
    @(negedge clk); rx = 1'b0;          // second edge in the same bit
    wait_ss(s);
    chk(s - c == 28, "R7 R9 lengthened by min(3,J+1)=2 quanta", s - c, 28);
    chk(sample_bit == 1'b0, "R3 sampled level", int'(sample_bit), 0);
    rx = 1'b1;
    wait_tx(c); wait_tx(c);

    // R8 shorten: edge at index 0 of phase 2, B+1=3, J+1=2
    wait_ss(s);
    rx = 1'b0;
    wait_tx(c);
    chk(c - s == 4, "R8 shortened by 2 quanta", c - s, 4);
    rx = 1'b1;
    wait_tx(c); wait_tx(c);

    // R6 hard sync while idle
    bus_idle = 1'b1;
    wait_tx(c);
    repeat (5) @(negedge clk);
    n = cyc; rx = 1'b0;
    wait_ss(s);
    chk(s - n == 22, "R6 hard sync restart delay", s - n, 22);
    chk(sample_bit == 1'b0, "R6 sampled level after hard sync", int'(sample_bit), 0);
    @(negedge clk);
    chk(!tx_strobe, "R4 no tx_strobe from hard sync", int'(tx_strobe), 0);
    rx = 1'b1; bus_idle = 1'b0;
    wait_tx(c); wait_tx(c);

    // R5 triple vs single sampling: quantum 6, A=5, B=1, J=0
    init_mode = 1'b1;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h95);
    init_mode = 1'b0;
    wait_tx(c); wait_tx(c);
    vote_trial(1'b0, "R5 triple vote rejects one-tick glitch");
    init_mode = 1'b1;
    wr(1'b1, 8'h15);
    init_mode = 1'b0;
    wait_tx(c); wait_tx(c);
    vote_trial(1'b1, "R5 single sample takes glitch level");

    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule